// File: doc/BRIEF.md
# Power-Fail Shadowed Static Memory Controller

This block is a clocked model of a 512-word by 8-bit static memory in which every word has a nonvolatile shadow copy. In normal operation the host uses an asynchronous-style port with active-low chip select, output enable and write enable, a 9-bit address, and separate data-in and data-out buses. An output-valid flag stands in for the tri-state data bus. Reads are combinational from the addressed word. A write commits at the rising clock edge.

A single power-good input drives the shadow traffic, and the host issues no commands for it. When power-good falls, the whole array is copied into the shadow (store). When power-good rises, the shadow is copied back into the array (recall). Each copy moves one 32-byte row per clock, so it takes 16 cycles. While a copy runs, the busy output is high and the host port is locked out.

The sequencer has three named states:

- **IDLE**: the port is live.
- **STORE**: array rows are copied into the shadow.
- **RECALL**: shadow rows are copied into the array.

The transitions are:

- IDLE→RECALL on a power-good rise.
- IDLE→STORE on a power-good fall.
- STORE→IDLE, or STORE→RECALL if power-good is high when the last row is done.
- RECALL→IDLE, or RECALL→STORE if power-good is low when the last row is done.

A normal reset returns the sequencer to IDLE. A separate cold reset is the only thing that clears the shadow.

Top module: `nvsram_ctrl`

## Requirements
- R1: Each of the 512 addresses holds its own byte. Address bits 8..5 select one of 16 rows, and bits 4..0 select one of 32 bytes in that row.
- R2: While idle, `dout` shows the byte at `addr` in the same cycle. A byte on `din` is written at the rising edge when `ce_n`=0, `we_n`=0 and `busy`=0.
- R3: `dout_en` is 1 only when `ce_n`=0, `we_n`=1, `oe_n`=0 and `busy`=0. Otherwise `dout_en` is 0 and `dout` is 0. A cycle with `ce_n`=1, or with `we_n`=1 and `oe_n`=1, changes no stored byte.
- R4: A power-good rise seen while idle starts a RECALL. `busy` is high from the next edge for exactly 16 cycles. Afterwards every word equals its shadow copy.
- R5: A power-good fall seen while idle starts a STORE. `busy` is high for exactly 16 cycles. Afterwards the shadow equals the array.
- R6: While `busy`=1, writes are ignored and `dout_en` stays 0.
- R7: `stby` is 1 only when `ce_n`=1 and `busy`=0. Deselecting during a copy does not enter standby.
- R8: Only `cold_rst_n` clears the shadow, to all zeros. `rst_n` and power-good toggles leave it intact.
- R9: A power-good rise during a STORE lets the STORE finish, and a RECALL follows with no idle cycle (32 busy cycles). A power-good fall during a RECALL likewise makes a STORE follow.
- R10: After `rst_n`: `busy`=0, `dout_en`=0, and the sequencer is in IDLE. If `pwr_good` is high at release, a RECALL starts at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| cold_rst_n | input | 1 | Asynchronous active-low reset that clears the shadow |
| pwr_good | input | 1 | Supply-good level, synchronous to `clk` |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 9 | Word address: row in bits 8..5, byte in bits 4..0 |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Read data is being driven (bus out of high-Z) |
| busy | output | 1 | A store or recall is in progress |
| stby | output | 1 | Device is in standby |

## Verification
Read data and `dout_en` are combinational, so the bench drives the port at a falling edge and samples 1 ns later. A write is due at the following rising edge, and the bench reads it back at the next falling edge.

`busy` rises at the first rising edge that sees the power-good change. The bench therefore starts counting busy cycles at the next falling edge and expects exactly 16, or 32 for a chained copy. It probes the locked-out port only inside that window. Array and shadow contents are checked through full 512-address read sweeps after each copy ends, against patterns the bench computes from the address.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STORE  = 2'd1,
        ST_RECALL = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/nvs_seq.sv
`timescale 1ns/1ps
module nvs_seq #(
    parameter int ROWS = 16,
    localparam int RW = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    output logic          busy,
    output logic          do_store,
    output logic          do_recall,
    output logic [RW-1:0] row
);
    import nvs_pkg::*;

    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

    xfer_state_e   state_q, state_d;
    logic [RW-1:0] row_q, row_d;
    logic          pg_q;
    logic          pg_rise, pg_fall;

    assign pg_rise = pwr_good & ~pg_q;
    assign pg_fall = ~pwr_good & pg_q;

    // next state
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        unique case (state_q)
            ST_IDLE: begin
                row_d = '0;
                if (pg_rise)      state_d = ST_RECALL;
                else if (pg_fall) state_d = ST_STORE;
            end
            ST_STORE: begin
                row_d = row_q + RW'(1);
                if (row_q == LAST_ROW) begin
                    row_d   = '0;
                    state_d = pwr_good ? ST_RECALL : ST_IDLE;
                end
            end
            ST_RECALL: begin
                row_d = row_q + RW'(1);
                if (row_q == LAST_ROW) begin
                    row_d   = '0;
                    state_d = pwr_good ? ST_IDLE : ST_STORE;
                end
            end
            default: begin
                row_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            pg_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            pg_q    <= pwr_good;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        do_store  = (state_q == ST_STORE);
        do_recall = (state_q == ST_RECALL);
        row       = row_q;
    end
endmodule

// File: rtl/nvs_port.sv
`timescale 1ns/1ps
module nvs_port (
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic busy,
    output logic wr_en,
    output logic rd_en,
    output logic stby
);
    always_comb begin
        wr_en = ~busy & ~ce_n & ~we_n;
        rd_en = ~busy & ~ce_n & we_n & ~oe_n;
        stby  = ce_n & ~busy;
    end
endmodule

// File: rtl/nvs_array.sv
`timescale 1ns/1ps
module nvs_array #(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int DW   = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int RB  = COLS * DW
) (
    input  logic          clk,
    input  logic          cold_rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] acc_row,
    input  logic [CW-1:0] acc_col,
    input  logic [DW-1:0] wr_data,
    input  logic          do_store,
    input  logic          do_recall,
    input  logic [RW-1:0] xfer_row,
    output logic [DW-1:0] rd_data
);
    logic [RB-1:0] sram_q [ROWS];
    logic [RB-1:0] shad_q [ROWS];

    // volatile array: host writes or a recall row
    always_ff @(posedge clk) begin
        if (do_recall)
            sram_q[xfer_row] <= shad_q[xfer_row];
        else if (wr_en)
            sram_q[acc_row][acc_col*DW +: DW] <= wr_data;
    end

    // nonvolatile shadow: cleared only by cold reset
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            for (int r = 0; r < ROWS; r++)
                shad_q[r] <= '0;
        end else if (do_store) begin
            shad_q[xfer_row] <= sram_q[xfer_row];
        end
    end

    assign rd_data = sram_q[acc_row][acc_col*DW +: DW];
endmodule

// File: rtl/nvsram_ctrl.sv
`timescale 1ns/1ps
module nvsram_ctrl #(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int DW   = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int AW  = RW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cold_rst_n,
    input  logic          pwr_good,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          busy,
    output logic          stby
);
    logic          do_store, do_recall, wr_en, rd_en;
    logic [RW-1:0] xfer_row;
    logic [DW-1:0] rd_data;

    nvs_seq #(.ROWS(ROWS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .busy      (busy),
        .do_store  (do_store),
        .do_recall (do_recall),
        .row       (xfer_row)
    );

    nvs_port u_port (
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .busy  (busy),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .stby  (stby)
    );

    nvs_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .wr_en      (wr_en),
        .acc_row    (addr[AW-1:CW]),
        .acc_col    (addr[CW-1:0]),
        .wr_data    (din),
        .do_store   (do_store),
        .do_recall  (do_recall),
        .xfer_row   (xfer_row),
        .rd_data    (rd_data)
    );

    assign dout_en = rd_en;
    assign dout    = rd_en ? rd_data : '0;
endmodule

// File: rtl/nvs_chk.sv
`timescale 1ns/1ps
module nvs_chk #(
    parameter int ROWS = 16,
    parameter int DW   = 8,
    localparam int CNW = $clog2(2 * ROWS) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic          busy,
    input logic          stby
);
    logic [CNW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + CNW'(1);
        else           run_q <= '0;
    end

    p_read_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && we_n && !oe_n));

    p_dout_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

    p_busy_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dout_en);

    p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !stby);

    p_rise_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $rose(pwr_good)) |=> busy);

    p_run_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < CNW'(2 * ROWS)));

    p_run_whole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q != '0 && (run_q % CNW'(ROWS)) == '0));
endmodule

bind nvsram_ctrl nvs_chk #(.ROWS(ROWS), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dout     (dout),
    .dout_en  (dout_en),
    .busy     (busy),
    .stby     (stby)
);

// File: tb/sim_nvsram_ctrl.sv
`timescale 1ns/1ps
module sim_nvsram_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, cold_rst_n, pwr_good, ce_n, oe_n, we_n;
    logic [8:0] addr;
    logic [7:0] din, dout;
    logic       dout_en, busy, stby;
    int         n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    nvsram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n), .pwr_good(pwr_good),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy(busy), .stby(stby)
    );

    function automatic logic [7:0] pat_f(int a);
        return 8'((a * 37 + (a >> 8) * 91 + 5) & 255);
    endfunction
    function automatic logic [7:0] pat_g(int a);
        return ~pat_f(a) ^ 8'h5A;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        addr = 9'(a); din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd(string req, int a, logic [7:0] exp);
        @(negedge clk);
        addr = 9'(a); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        #1;
        chk(req, dout, exp);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic busy_run(output int c);
        c = 0;
        @(negedge clk);
        while (busy && c < 200) begin
            c++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c;
        logic [7:0] model;
        rst_n = 0; cold_rst_n = 0; pwr_good = 0;
        ce_n = 1; oe_n = 1; we_n = 1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        chk("R10 busy after reset", busy, 0);
        chk("R10 dout_en after reset", dout_en, 0);
        chk("R7 standby when deselected", stby, 1);
        rst_n = 1; cold_rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R10 no copy with power low", busy, 0);

        // power-up recall of a cold-cleared shadow
        pwr_good = 1;
        busy_run(c);
        chk("R4 recall length", c, 16);
        for (int a = 0; a < 512; a++) rd("R8 cold shadow zero", a, 8'h00);

        // fill and read back every address
        for (int a = 0; a < 512; a++) wr(a, pat_f(a));
        for (int a = 0; a < 512; a++) rd("R1 R2 readback", a, pat_f(a));

        // truth table sweep at one address
        model = pat_f(9);
        for (int k = 0; k < 8; k++) begin
            logic ce, we, oe;
            ce = k[2]; we = k[1]; oe = k[0];
            @(negedge clk);
            addr = 9'd9; din = 8'hC0 | 8'(k); ce_n = ce; we_n = we; oe_n = oe;
            #1;
            chk("R3 dout_en by truth table", dout_en, {31'd0, (!ce && we && !oe)});
            if (!ce && we && !oe) chk("R3 driven data", dout, model);
            else                  chk("R3 quiet data", dout, 0);
            @(negedge clk);
            ce_n = 1; we_n = 1; oe_n = 1;
            if (!ce && !we) model = 8'hC0 | 8'(k);
            rd("R3 write only on select and write", 9, model);
        end
        wr(9, pat_f(9));

        // store on power loss
        @(negedge clk);
        pwr_good = 0;
        busy_run(c);
        chk("R5 store length", c, 16);

        // recall on power return, probe the locked port
        pwr_good = 1;
        @(negedge clk);
        chk("R4 busy after rise", busy, 1);
        addr = 9'd3; ce_n = 0; we_n = 1; oe_n = 0;
        #1;
        chk("R6 no read while busy", dout_en, 0);
        ce_n = 1; oe_n = 1;
        #1;
        chk("R7 no standby while busy", stby, 0);
        wr(3, 8'hEE);
        while (busy) @(negedge clk);
        chk("R7 standby after copy", stby, 1);
        rd("R6 write ignored while busy", 3, pat_f(3));
        for (int a = 0; a < 512; a++) rd("R5 R4 store then recall", a, pat_f(a));

        // normal reset keeps shadow, power-up recall restores it
        for (int a = 0; a < 512; a++) wr(a, pat_g(a));
        rd("R2 overwrite", 100, pat_g(100));
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R10 busy in reset", busy, 0);
        rst_n = 1;
        busy_run(c);
        chk("R10 recall after reset with power high", c, 16);
        for (int a = 0; a < 512; a++) rd("R8 shadow kept over reset", a, pat_f(a));

        // power returns during a store
        for (int a = 0; a < 512; a++) wr(a, pat_g(a));
        @(negedge clk);
        pwr_good = 0;
        c = 0;
        @(negedge clk);
        for (int i = 0; i < 200 && busy; i++) begin
            c++;
            if (c == 5) pwr_good = 1;
            @(negedge clk);
        end
        chk("R9 store then recall chained", c, 32);
        for (int a = 0; a < 512; a++) rd("R9 stored data recalled", a, pat_g(a));

        // power lost during a recall
        @(negedge clk);
        pwr_good = 0;
        busy_run(c);
        chk("R5 store length again", c, 16);
        pwr_good = 1;
        c = 0;
        @(negedge clk);
        for (int i = 0; i < 200 && busy; i++) begin
            c++;
            if (c == 5) pwr_good = 0;
            @(negedge clk);
        end
        chk("R9 recall then store chained", c, 32);

        // cold reset clears the shadow
        @(negedge clk);
        rst_n = 0; cold_rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1; cold_rst_n = 1;
        @(negedge clk);
        pwr_good = 1;
        busy_run(c);
        chk("R4 recall after cold reset", c, 16);
        for (int a = 0; a < 512; a++) rd("R8 cold reset clears shadow", a, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule